// File: doc/BRIEF.md
# Conditional-Flag Shift and Rotate Unit

This block is the shift and rotate execution slice of a 32-bit integer core. Each operation is qualified by a valid strobe and supplies a primary operand, a secondary operand, a shift count, a 3-bit operation code and the current sign, zero and carry flags. It returns the shifted word and the next flag values one clock later. The whole shift completes in one pass through a logarithmic barrel network, so the latency is the same for every count.

Only the low five bits of the count are used. The flags follow rules that depend on the class of the operation. Plain shifts rewrite sign, zero and carry only when the masked count is nonzero. Rotates write only the carry and never touch sign or zero. Double shifts take their vacated bits from the secondary operand. When the masked count is zero, every operation leaves the operand and all three flags exactly as they came in.

Top module: `shrot_unit`

## Requirements
- R1: The effective count is the count input modulo 32, which is its low five bits. Counts 32 and 33 give the same result and flags as counts 0 and 1.
- R2: For a nonzero effective count n, opcode 000 (shift left) returns the operand shifted left by n with zeros filled in. Opcode 001 (logical shift right) returns it shifted right by n with zeros filled in.
- R3: For opcodes 000 and 001 with a nonzero n, the sign flag output equals result bit 31, and the zero flag output is 1 exactly when all 32 result bits are 0.
- R4: For opcodes 000 and 001 with a nonzero n, the carry output is the last bit shifted out. For shift left this is operand bit 32−n. For shift right it is operand bit n−1.
- R5: When n is zero, every opcode returns the primary operand unchanged and passes all three flags through unchanged.
- R6: Opcode 010 (rotate left) and opcode 011 (rotate right) rotate the operand by n. For a nonzero n the carry output equals result bit 0 for rotate left and result bit 31 for rotate right. The sign and zero flags always pass through unchanged on a rotate.
- R7: Opcode 100 (double left) returns (A<<n)|(B>>(32−n)). Opcode 101 (double right) returns (A>>n)|(B<<(32−n)). For a nonzero n, the flags are set as in R3 and R4, with the carry taken from A.
- R8: Opcodes 110 and 111 return the primary operand unchanged and pass all flags through unchanged.
- R9: Outputs are registered. The valid output is high in the cycle after a cycle with the valid input high, and low otherwise. Result and flag outputs hold their value while no operation is issued.
- R10: While reset is high, the valid output, the result and all flag outputs are cleared to 0 on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies an operation in this cycle |
| op_code | input | 3 | Operation selector (see R2, R6, R7, R8) |
| src_a | input | 32 | Primary operand, the word that moves |
| src_b | input | 32 | Fill operand for the double shifts |
| src_cnt | input | 8 | Shift count; only the low five bits are used |
| sf_in | input | 1 | Current sign flag |
| zf_in | input | 1 | Current zero flag |
| cf_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Result and flags valid |
| result | output | 32 | Shifted or rotated word |
| sf_out | output | 1 | Next sign flag |
| zf_out | output | 1 | Next zero flag |
| cf_out | output | 1 | Next carry flag |

## Verification
The bound checker watches several rules on every cycle. It checks the one-cycle valid latency and the clearing by reset. It checks that a zero masked count, or an unassigned opcode, returns the operand and the flags untouched. It checks that rotates never alter sign or zero, and that a counting shift derives sign and zero from its own result. Which bit the carry takes and the exact bit pattern of each shift, rotate and double shift are shown only by the bench's scenarios. These compare against a model that moves the operand one bit per step. The boundary counts 0, 1, 31, 32 and 33 are part of those scenarios, including a direct comparison of count 32 against count 0.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

    localparam int unsigned WORD_W = 32;

    typedef enum logic [2:0] {
        OP_SHL  = 3'b000,
        OP_SHR  = 3'b001,
        OP_ROL  = 3'b010,
        OP_ROR  = 3'b011,
        OP_DSHL = 3'b100,
        OP_DSHR = 3'b101
    } shrot_op_e;

    typedef enum logic [1:0] {
        CLS_SHIFT = 2'd0,
        CLS_ROT   = 2'd1,
        CLS_DBL   = 2'd2,
        CLS_NONE  = 2'd3
    } shrot_class_e;

    typedef struct packed {
        logic sf;
        logic zf;
        logic cf;
    } shrot_flags_t;

    function automatic shrot_class_e op_class(input logic [2:0] op);
        shrot_class_e c;
        case (op)
            OP_SHL, OP_SHR:   c = CLS_SHIFT;
            OP_ROL, OP_ROR:   c = CLS_ROT;
            OP_DSHL, OP_DSHR: c = CLS_DBL;
            default:          c = CLS_NONE;
        endcase
        return c;
    endfunction

    function automatic logic op_moves_left(input logic [2:0] op);
        return (op == OP_SHL) || (op == OP_ROL) || (op == OP_DSHL);
    endfunction

endpackage

// File: rtl/shrot_funnel.sv
module shrot_funnel #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = $clog2(DATA_W),
    parameter bit          LEFT   = 1'b1
) (
    input  logic [DATA_W-1:0] main_i,
    input  logic [DATA_W-1:0] fill_i,
    input  logic [CNT_W-1:0]  amt_i,
    output logic [DATA_W-1:0] res_o,
    output logic              carry_o
);
    localparam int unsigned EXT_W = 2 * DATA_W + 1;

    logic [EXT_W-1:0] stage [CNT_W+1];

    generate
        if (LEFT) begin : g_left_seed
            assign stage[0] = {1'b0, main_i, fill_i};
        end else begin : g_right_seed
            assign stage[0] = {fill_i, main_i, 1'b0};
        end

        for (genvar s = 0; s < CNT_W; s++) begin : g_stage
            if (LEFT) begin : g_l
                assign stage[s+1] = amt_i[s] ? (stage[s] << (2 ** s)) : stage[s];
            end else begin : g_r
                assign stage[s+1] = amt_i[s] ? (stage[s] >> (2 ** s)) : stage[s];
            end
        end

        if (LEFT) begin : g_left_out
            assign res_o   = stage[CNT_W][2*DATA_W-1:DATA_W];
            assign carry_o = stage[CNT_W][2*DATA_W];
        end else begin : g_right_out
            assign res_o   = stage[CNT_W][DATA_W:1];
            assign carry_o = stage[CNT_W][0];
        end
    endgenerate

endmodule

// File: rtl/shrot_flag_logic.sv
module shrot_flag_logic
    import shrot_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [2:0]        op_i,
    input  logic              amt_zero_i,
    input  logic [DATA_W-1:0] shifted_i,
    input  logic              carry_i,
    input  logic [DATA_W-1:0] passthru_i,
    input  shrot_flags_t      flags_i,
    output logic [DATA_W-1:0] res_o,
    output shrot_flags_t      flags_o
);
    shrot_class_e cls;

    always_comb begin
        cls     = op_class(op_i);
        res_o   = passthru_i;
        flags_o = flags_i;
        if (!amt_zero_i) begin
            case (cls)
                CLS_SHIFT, CLS_DBL: begin
                    res_o      = shifted_i;
                    flags_o.sf = shifted_i[DATA_W-1];
                    flags_o.zf = (shifted_i == '0);
                    flags_o.cf = carry_i;
                end
                CLS_ROT: begin
                    res_o      = shifted_i;
                    flags_o.cf = carry_i;
                end
                default: begin
                    res_o   = passthru_i;
                    flags_o = flags_i;
                end
            endcase
        end
    end

endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
    import shrot_pkg::*;
#(
    parameter int unsigned DATA_W   = WORD_W,
    parameter int unsigned CNT_IN_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [2:0]          op_code,
    input  logic [DATA_W-1:0]   src_a,
    input  logic [DATA_W-1:0]   src_b,
    input  logic [CNT_IN_W-1:0] src_cnt,
    input  logic                sf_in,
    input  logic                zf_in,
    input  logic                cf_in,
    output logic                out_valid,
    output logic [DATA_W-1:0]   result,
    output logic                sf_out,
    output logic                zf_out,
    output logic                cf_out
);
    localparam int unsigned CNT_W = $clog2(DATA_W);

    logic [CNT_W-1:0]  amt;
    logic [DATA_W-1:0] fill_l, fill_r;
    logic [DATA_W-1:0] res_l, res_r, shifted, next_res;
    logic              carry_l, carry_r, carry;
    shrot_flags_t      flags_cur, flags_next;

    assign amt       = src_cnt[CNT_W-1:0];
    assign flags_cur = '{sf: sf_in, zf: zf_in, cf: cf_in};

    always_comb begin
        case (op_code)
            OP_ROL:  fill_l = src_a;
            OP_DSHL: fill_l = src_b;
            default: fill_l = '0;
        endcase
        case (op_code)
            OP_ROR:  fill_r = src_a;
            OP_DSHR: fill_r = src_b;
            default: fill_r = '0;
        endcase
    end

    shrot_funnel #(.DATA_W(DATA_W), .CNT_W(CNT_W), .LEFT(1'b1)) u_left (
        .main_i (src_a),
        .fill_i (fill_l),
        .amt_i  (amt),
        .res_o  (res_l),
        .carry_o(carry_l)
    );

    shrot_funnel #(.DATA_W(DATA_W), .CNT_W(CNT_W), .LEFT(1'b0)) u_right (
        .main_i (src_a),
        .fill_i (fill_r),
        .amt_i  (amt),
        .res_o  (res_r),
        .carry_o(carry_r)
    );

    assign shifted = op_moves_left(op_code) ? res_l   : res_r;
    assign carry   = op_moves_left(op_code) ? carry_l : carry_r;

    shrot_flag_logic #(.DATA_W(DATA_W)) u_flags (
        .op_i      (op_code),
        .amt_zero_i(amt == '0),
        .shifted_i (shifted),
        .carry_i   (carry),
        .passthru_i(src_a),
        .flags_i   (flags_cur),
        .res_o     (next_res),
        .flags_o   (flags_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            sf_out    <= 1'b0;
            zf_out    <= 1'b0;
            cf_out    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= next_res;
                sf_out <= flags_next.sf;
                zf_out <= flags_next.zf;
                cf_out <= flags_next.cf;
            end
        end
    end

endmodule

// File: rtl/shrot_unit_checker.sv
module shrot_unit_checker #(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned CNT_IN_W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic [2:0]          op_code,
    input logic [DATA_W-1:0]   src_a,
    input logic [CNT_IN_W-1:0] src_cnt,
    input logic                sf_in,
    input logic                zf_in,
    input logic                cf_in,
    input logic                out_valid,
    input logic [DATA_W-1:0]   result,
    input logic                sf_out,
    input logic                zf_out,
    input logic                cf_out
);
    localparam int unsigned CNT_W = $clog2(DATA_W);

    logic amt_zero;
    assign amt_zero = (src_cnt[CNT_W-1:0] == '0);

    // R9: valid follows the strobe by exactly one cycle
    p_valid_follows_r9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_valid_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R10: reset clears outputs
    p_reset_clear_r10: assert property (@(posedge clk)
        rst |=> (!out_valid && result == '0 && !sf_out && !zf_out && !cf_out));

    // R5: zero masked count is a full no-op
    p_zero_count_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && amt_zero) |=>
            (result == $past(src_a) && sf_out == $past(sf_in) &&
             zf_out == $past(zf_in) && cf_out == $past(cf_in)));

    // R6: rotates keep sign and zero
    p_rot_keeps_sz_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op_code == 3'b010 || op_code == 3'b011)) |=>
            (sf_out == $past(sf_in) && zf_out == $past(zf_in)));

    // R3: counting shift sets sign and zero from its result
    p_shift_sz_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !amt_zero && (op_code == 3'b000 || op_code == 3'b001)) |=>
            (sf_out == result[DATA_W-1] && zf_out == (result == '0)));

    // R8: unassigned opcodes pass through
    p_unassigned_op_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_code[2:1] == 2'b11) |=>
            (result == $past(src_a) && sf_out == $past(sf_in) &&
             zf_out == $past(zf_in) && cf_out == $past(cf_in)));

endmodule

bind shrot_unit shrot_unit_checker #(.DATA_W(DATA_W), .CNT_IN_W(CNT_IN_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .op_code  (op_code),
    .src_a    (src_a),
    .src_cnt  (src_cnt),
    .sf_in    (sf_in),
    .zf_in    (zf_in),
    .cf_in    (cf_in),
    .out_valid(out_valid),
    .result   (result),
    .sf_out   (sf_out),
    .zf_out   (zf_out),
    .cf_out   (cf_out)
);

// File: tb/shrot_unit_tb_top.sv
`timescale 1ns/100ps
module shrot_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [2:0]  op_code = 3'b000;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [7:0]  src_cnt = '0;
    logic        sf_in = 1'b0, zf_in = 1'b0, cf_in = 1'b0;
    logic        out_valid;
    logic [31:0] result;
    logic        sf_out, zf_out, cf_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [31:0] last_res;
    logic [2:0]  last_flags;

    always #2.5 clk = ~clk;

    shrot_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_code(op_code),
        .src_a(src_a), .src_b(src_b), .src_cnt(src_cnt),
        .sf_in(sf_in), .zf_in(zf_in), .cf_in(cf_in),
        .out_valid(out_valid), .result(result),
        .sf_out(sf_out), .zf_out(zf_out), .cf_out(cf_out)
    );

    // Reference: moves the word one bit per step, flags applied at the end.
    function automatic logic [34:0] ref_model(input logic [2:0] op, input logic [31:0] a,
                                              input logic [31:0] b, input logic [7:0] cnt,
                                              input logic [2:0] fl);
        int n = int'(cnt % 8'd32);
        logic [31:0] w = a;
        logic [31:0] f = b;
        logic sf = fl[2], zf = fl[1], cf = fl[0];
        if (n == 0 || op > 3'b101) return {a, fl};
        for (int i = 0; i < n; i++) begin
            case (op)
                3'b000: begin cf = w[31]; w = w << 1; end
                3'b001: begin cf = w[0];  w = w >> 1; end
                3'b010: begin cf = w[31]; w = {w[30:0], w[31]}; end
                3'b011: begin cf = w[0];  w = {w[0], w[31:1]}; end
                3'b100: begin cf = w[31]; w = {w[30:0], f[31]}; f = f << 1; end
                default: begin cf = w[0]; w = {f[0], w[31:1]}; f = f >> 1; end
            endcase
        end
        if (op != 3'b010 && op != 3'b011) begin
            sf = w[31];
            zf = (w == 32'd0);
        end
        return {w, sf, zf, cf};
    endfunction

    function automatic string tag_of(input logic [2:0] op, input logic [7:0] cnt, input int fld);
        if (cnt[4:0] == 5'd0) return "R5";
        case (op)
            3'b000, 3'b001: return (fld == 0) ? "R2" : (fld == 3) ? "R4" : "R3";
            3'b010, 3'b011: return "R6";
            3'b100, 3'b101: return "R7";
            default:        return "R8";
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                          input logic [7:0] cnt, input logic [2:0] fl);
        logic [34:0] e = ref_model(op, a, b, cnt, fl);
        @(negedge clk);
        in_valid = 1'b1; op_code = op; src_a = a; src_b = b; src_cnt = cnt;
        {sf_in, zf_in, cf_in} = fl;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R9", "out_valid", {31'd0, out_valid}, 32'd1);
        chk(tag_of(op, cnt, 0), "result", result, e[34:3]);
        chk(tag_of(op, cnt, 1), "sf", {31'd0, sf_out}, {31'd0, e[2]});
        chk(tag_of(op, cnt, 2), "zf", {31'd0, zf_out}, {31'd0, e[1]});
        chk(tag_of(op, cnt, 3), "cf", {31'd0, cf_out}, {31'd0, e[0]});
        last_res   = result;
        last_flags = {sf_out, zf_out, cf_out};
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] vals [4];
        logic [7:0]  cnts [5];
        void'($urandom(32'h5EED_1234));
        vals[0] = 32'h8000_0001; vals[1] = 32'hFFFF_FFFF;
        vals[2] = 32'h0000_0000; vals[3] = 32'h1234_5678;
        cnts[0] = 8'd0; cnts[1] = 8'd1; cnts[2] = 8'd31; cnts[3] = 8'd32; cnts[4] = 8'd33;

        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10", "out_valid", {31'd0, out_valid}, 32'd0);
        chk("R10", "result", result, 32'd0);
        chk("R10", "flags", {29'd0, sf_out, zf_out, cf_out}, 32'd0);
        @(negedge clk);
        rst = 1'b0;

        // Directed: every opcode against the boundary counts
        for (int op = 0; op < 8; op++)
            for (int ci = 0; ci < 5; ci++)
                for (int vi = 0; vi < 4; vi++)
                    run_op(3'(op), vals[vi], ~vals[(vi + 1) % 4], cnts[ci], 3'(vi + ci));

        // R1: count 32 equals count 0, count 33 equals count 1
        for (int op = 0; op < 6; op++) begin
            logic [31:0] r0;
            logic [2:0]  f0;
            run_op(3'(op), 32'hC3A5_0F81, 32'h7E11_9B02, 8'd0, 3'b101);
            r0 = last_res; f0 = last_flags;
            run_op(3'(op), 32'hC3A5_0F81, 32'h7E11_9B02, 8'd32, 3'b101);
            chk("R1", "count32 result", last_res, r0);
            chk("R1", "count32 flags", {29'd0, last_flags}, {29'd0, f0});
            run_op(3'(op), 32'hC3A5_0F81, 32'h7E11_9B02, 8'd1, 3'b010);
            r0 = last_res; f0 = last_flags;
            run_op(3'(op), 32'hC3A5_0F81, 32'h7E11_9B02, 8'd33, 3'b010);
            chk("R1", "count33 result", last_res, r0);
            chk("R1", "count33 flags", {29'd0, last_flags}, {29'd0, f0});
        end

        // R3: zero flag set by a shift that empties the word
        run_op(3'b000, 32'h0000_0001, 32'd0, 8'd32 + 8'd31 + 8'd1, 3'b000);
        run_op(3'b001, 32'h0000_0001, 32'd0, 8'd1, 3'b100);
        chk("R3", "zf after emptying shift", {31'd0, zf_out}, 32'd1);

        // R9: idle cycle holds outputs and drops valid
        @(negedge clk);
        chk("R9", "idle out_valid", {31'd0, out_valid}, 32'd0);
        chk("R9", "idle holds result", result, last_res);

        // Random stimulus
        for (int k = 0; k < 600; k++)
            run_op(3'($urandom_range(0, 7)), $urandom(), $urandom(),
                   8'($urandom_range(0, 255)), 3'($urandom_range(0, 7)));

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule